// File: doc/BRIEF.md
# Dual-Channel Gate Command Mode Controller

This block sits between the logic that decides when a pair of power switches should conduct and the gate drive stages that turn them on. It takes two logic-level commands and produces two registered gate commands. A two-bit mode input selects how the commands are combined. In the pass-through mode, each channel follows its own command. In the complementary mode, only the first command is used: it drives one output directly and the other inverted, with a programmable dead gap between them. In the exclusive mode, the two outputs can never be on together.

Each channel has its own fault input. A fault turns that channel off at once and starts a programmable off-period, the blocking time. When that period ends, the channel comes back only after its command has been low, so a pulse already in progress is never resumed. A new mode request clears both outputs and holds them low for a dead-time interval before the new combining rule applies.

The mode sequencer has two states. `SEQ_RUN` moves to `SEQ_QUIET` when the requested mode differs from the active one. `SEQ_QUIET` moves back to `SEQ_RUN` and adopts the requested mode once its interval counter reaches the dead count. Each channel's fault blocker has four states:
- `BLK_READY` moves to `BLK_FAULT` when the fault input is high.
- `BLK_FAULT` stays put while the fault is high. When the fault clears, it moves to `BLK_HOLD` if the blocking count is non-zero. With a zero count it goes straight to `BLK_READY` if the command is low, and to `BLK_REARM` if the command is high.
- `BLK_HOLD` counts blocking cycles. When the count is reached it moves to `BLK_READY` if the command is low, or to `BLK_REARM` if the command is high.
- `BLK_REARM` moves to `BLK_READY` as soon as the command is low.
- A fault sends every state to `BLK_FAULT`.

Top module: `gate_cmd_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both gate outputs and both busy outputs are low.
- R2: In mode 0 (pass-through), each gate output equals its own command as sampled on the previous clock edge, with no dead gap, and both may be high together.
- R3: In mode 1 (complementary), gate A follows command A and gate B follows the inverse of command A; command B has no effect on either output.
- R4: In modes 1 and 2, a gate output rises exactly max(D,1) clock cycles after the other output falls, where D is the 10-bit dead count; it never rises while the other is high.
- R5: In mode 2 (exclusive), a gate is driven from its own command only while the other command is low; when both commands are high, both gates are low.
- R6: Outside mode 0, gate A and gate B are never high in the same cycle.
- R7: A high fault input forces that channel's gate low and its busy output high from the next clock edge.
- R8: With blocking count B and the command low, busy stays high and the gate stays off until the (B+1)-th clock edge that samples the fault low, where busy clears; B = 0 clears busy on the first such edge.
- R9: If the channel's command is high when blocking ends, busy stays high and the gate stays low until the command has been sampled low; only a later rising command turns the gate on.
- R10: When the mode input changes, both gates are low from the first edge that samples the new value through the following max(D,1) edges, and the new mode governs the outputs from the next edge.
- R11: Mode 3 holds both gate outputs low regardless of the commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_a | input | 1 | Command for channel A |
| cmd_b | input | 1 | Command for channel B |
| mode_sel | input | 2 | 0 pass-through, 1 complementary, 2 exclusive, 3 hold off |
| dead_cycles | input | 10 | Dead count D in clock cycles |
| block_cycles | input | 16 | Blocking count B in clock cycles |
| fault_a | input | 1 | Fault on channel A |
| fault_b | input | 1 | Fault on channel B |
| gate_a | output | 1 | Gate command, channel A |
| gate_b | output | 1 | Gate command, channel B |
| busy_a | output | 1 | Channel A is faulted, blocking, or waiting for its command to drop |
| busy_b | output | 1 | Channel B is faulted, blocking, or waiting for its command to drop |

## Verification
The stimulus drives both commands high together, toggles them one at a time, and swaps the two commands in a single cycle. Running these patterns in each mode separates the pass-through rule, where both outputs rise together, from the complementary rule, where command B is ignored, and from the exclusive rule, where both outputs drop. The swap patterns are timed to the exact cycle at a dead count of 3 and at a dead count of 0, which tells a correct max(D,1) gap from an off-by-one. Fault pulses are applied with the command low and with the command held high, and with a non-zero and a zero blocking count. These cases distinguish the exact blocking length from the wait for a fresh command edge.

// File: rtl/gate_cmd_pkg.sv
package gate_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT    = 2'd0,
        MODE_HALF      = 2'd1,
        MODE_INTERLOCK = 2'd2,
        MODE_HOLD      = 2'd3
    } gc_mode_e;

    typedef enum logic [1:0] {
        BLK_READY = 2'd0,
        BLK_FAULT = 2'd1,
        BLK_HOLD  = 2'd2,
        BLK_REARM = 2'd3
    } gc_blk_state_e;

    typedef enum logic {
        SEQ_RUN   = 1'b0,
        SEQ_QUIET = 1'b1
    } gc_seq_state_e;

endpackage

// File: rtl/gc_fault_blocker.sv
module gc_fault_blocker
    import gate_cmd_pkg::*;
#(
    parameter int BLOCK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_in,
    input  logic               cmd_in,
    input  logic [BLOCK_W-1:0] block_cycles,
    output logic               ready,
    output logic               busy
);

    localparam logic [BLOCK_W-1:0] CNT_ONE  = BLOCK_W'(1);
    localparam logic [BLOCK_W-1:0] CNT_ZERO = '0;

    gc_blk_state_e     state_q, state_d;
    logic [BLOCK_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_READY;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fault_in) begin
            state_d = BLK_FAULT;
            cnt_d   = CNT_ZERO;
        end else begin
            unique case (state_q)
                BLK_READY: begin
                    state_d = BLK_READY;
                end
                BLK_FAULT: begin
                    if (block_cycles == CNT_ZERO) begin
                        state_d = cmd_in ? BLK_REARM : BLK_READY;
                    end else begin
                        state_d = BLK_HOLD;
                        cnt_d   = CNT_ONE;
                    end
                end
                BLK_HOLD: begin
                    if (cnt_q >= block_cycles) begin
                        state_d = cmd_in ? BLK_REARM : BLK_READY;
                    end else begin
                        cnt_d = cnt_q + CNT_ONE;
                    end
                end
                BLK_REARM: begin
                    if (!cmd_in) begin
                        state_d = BLK_READY;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == BLK_READY);
        busy  = (state_q != BLK_READY);
    end

    // R7
    fault_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> busy);

    // R9
    rearm_needs_low_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!cmd_in));

endmodule

// File: rtl/gc_dead_guard.sv
module gc_dead_guard #(
    parameter int DEAD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_gate,
    input  logic              other_gate,
    input  logic              direct_mode,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              allow
);

    localparam logic [DEAD_W-1:0] LOW_ONE = DEAD_W'(1);
    localparam logic [DEAD_W:0]   EXT_ONE = (DEAD_W + 1)'(1);

    logic [DEAD_W-1:0] low_cnt_q;
    logic [DEAD_W:0]   low_next_ext;

    // cycles the opposite output has spent low, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (other_gate) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != '1) begin
            low_cnt_q <= low_cnt_q + LOW_ONE;
        end
    end

    always_comb begin
        low_next_ext = {1'b0, low_cnt_q} + EXT_ONE;
        allow = !other_gate && (low_next_ext >= {1'b0, dead_cycles});
    end

    // R4
    rise_after_other_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode && $rose(own_gate)) |-> $past(!other_gate));

endmodule

// File: rtl/gc_mode_sequencer.sv
module gc_mode_sequencer
    import gate_cmd_pkg::*;
#(
    parameter int DEAD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic [DEAD_W-1:0] dead_cycles,
    output gc_mode_e          active_mode,
    output logic              run_ok
);

    localparam logic [DEAD_W-1:0] Q_ONE = DEAD_W'(1);

    gc_seq_state_e     state_q, state_d;
    gc_mode_e          mode_q, mode_d;
    gc_mode_e          mode_req;
    logic [DEAD_W-1:0] qcnt_q, qcnt_d;

    assign mode_req = gc_mode_e'(mode_sel);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
            mode_q  <= MODE_DIRECT;
            qcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            qcnt_q  <= qcnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        qcnt_d  = qcnt_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (mode_req != mode_q) begin
                    state_d = SEQ_QUIET;
                    qcnt_d  = Q_ONE;
                end
            end
            SEQ_QUIET: begin
                if (qcnt_q >= dead_cycles) begin
                    state_d = SEQ_RUN;
                    mode_d  = mode_req;
                end else begin
                    qcnt_d = qcnt_q + Q_ONE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        active_mode = mode_q;
        run_ok      = (state_q == SEQ_RUN) && (mode_req == mode_q);
    end

endmodule

// File: rtl/gate_cmd_ctrl.sv
module gate_cmd_ctrl
    import gate_cmd_pkg::*;
#(
    parameter int DEAD_W  = 10,
    parameter int BLOCK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_a,
    input  logic               cmd_b,
    input  logic [1:0]         mode_sel,
    input  logic [DEAD_W-1:0]  dead_cycles,
    input  logic [BLOCK_W-1:0] block_cycles,
    input  logic               fault_a,
    input  logic               fault_b,
    output logic               gate_a,
    output logic               gate_b,
    output logic               busy_a,
    output logic               busy_b
);

    localparam int NCH = 2;

    gc_mode_e         active_mode;
    logic             run_ok;
    logic             direct_mode;
    logic [NCH-1:0]   fault_v, raw_v, ready_v, busy_v, allow_v, req_v;
    logic [NCH-1:0]   gate_q;

    assign fault_v     = {fault_b, fault_a};
    assign direct_mode = (active_mode == MODE_DIRECT);

    gc_mode_sequencer #(.DEAD_W(DEAD_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_sel    (mode_sel),
        .dead_cycles (dead_cycles),
        .active_mode (active_mode),
        .run_ok      (run_ok)
    );

    // per-mode combining of the two commands
    always_comb begin
        unique case (active_mode)
            MODE_DIRECT:    raw_v = {cmd_b, cmd_a};
            MODE_HALF:      raw_v = {~cmd_a, cmd_a};
            MODE_INTERLOCK: raw_v = {cmd_b & ~cmd_a, cmd_a & ~cmd_b};
            MODE_HOLD:      raw_v = '0;
        endcase
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        gc_fault_blocker #(.BLOCK_W(BLOCK_W)) u_blk (
            .clk          (clk),
            .rst_n        (rst_n),
            .fault_in     (fault_v[ch]),
            .cmd_in       (raw_v[ch]),
            .block_cycles (block_cycles),
            .ready        (ready_v[ch]),
            .busy         (busy_v[ch])
        );

        gc_dead_guard #(.DEAD_W(DEAD_W)) u_dg (
            .clk         (clk),
            .rst_n       (rst_n),
            .own_gate    (gate_q[ch]),
            .other_gate  (gate_q[NCH-1-ch]),
            .direct_mode (direct_mode),
            .dead_cycles (dead_cycles),
            .allow       (allow_v[ch])
        );

        assign req_v[ch] = raw_v[ch] & ready_v[ch] & ~fault_v[ch];
    end

    // registered gate commands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= {NCH{run_ok}} & req_v & ({NCH{direct_mode}} | allow_v);
        end
    end

    assign gate_a = gate_q[0];
    assign gate_b = gate_q[1];
    assign busy_a = busy_v[0];
    assign busy_b = busy_v[1];

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode != MODE_DIRECT) |-> !(gate_a && gate_b));

    // R7
    fault_a_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_a |=> !gate_a);

    // R7
    fault_b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_b |=> !gate_b);

    // R10
    mode_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != $past(mode_sel)) |=> (!gate_a && !gate_b));

    // R11
    hold_mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_mode == MODE_HOLD) |=> (!gate_a && !gate_b));

endmodule

// File: tb/gate_cmd_ctrl_bench.sv
module gate_cmd_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_a, cmd_b, fault_a, fault_b;
    logic [1:0]  mode_sel;
    logic [9:0]  dead_cycles;
    logic [15:0] block_cycles;
    logic        gate_a, gate_b, busy_a, busy_b;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int         stamp;
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    gate_cmd_ctrl u_gate_cmd_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_a        (cmd_a),
        .cmd_b        (cmd_b),
        .mode_sel     (mode_sel),
        .dead_cycles  (dead_cycles),
        .block_cycles (block_cycles),
        .fault_a      (fault_a),
        .fault_b      (fault_b),
        .gate_a       (gate_a),
        .gate_b       (gate_b),
        .busy_a       (busy_a),
        .busy_b       (busy_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: push an expectation d cycles ahead
    task automatic exp_at(input int d, input logic ga, input logic gb,
                          input logic ba, input logic bb, input string tag);
        item_t it;
        it.stamp = cyc + d;
        it.exp   = {ga, gb, ba, bb};
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].stamp == cyc) begin
                checks++;
                if ({gate_a, gate_b, busy_a, busy_b} !== sb_q[i].exp) begin
                    fails++;
                    $display("FAIL %s at cycle %0d: gate_a,gate_b,busy_a,busy_b = %b, expected %b",
                             sb_q[i].tag, cyc, {gate_a, gate_b, busy_a, busy_b}, sb_q[i].exp);
                end
                sb_q.delete(i);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cmd_a = 1'b0; cmd_b = 1'b0; fault_a = 1'b0; fault_b = 1'b0;
        mode_sel = 2'd0; dead_cycles = 10'd3; block_cycles = 16'd5;
        tick(1);
        exp_at(1, 0, 0, 0, 0, "R1 in reset");
        tick(3);
        rst_n = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R1 after release");
        tick(2);

        // R2 pass-through
        cmd_a = 1'b1;
        exp_at(1, 1, 0, 0, 0, "R2 a alone"); tick(2);
        cmd_b = 1'b1;
        exp_at(1, 1, 1, 0, 0, "R2 both high"); tick(2);
        cmd_a = 1'b0;
        exp_at(1, 0, 1, 0, 0, "R2 b alone"); tick(2);
        cmd_a = 1'b1;
        exp_at(1, 1, 1, 0, 0, "R2 both again"); tick(2);

        // R10 switch to complementary, D=3
        mode_sel = 2'd1;
        exp_at(1, 0, 0, 0, 0, "R10 forced low");
        exp_at(4, 0, 0, 0, 0, "R10 still quiet");
        exp_at(5, 1, 0, 0, 0, "R10 new mode");
        tick(7);

        // R3 / R4 complementary with dead gap
        cmd_a = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R4 a falls");
        exp_at(3, 0, 0, 0, 0, "R4 gap");
        exp_at(4, 0, 1, 0, 0, "R4 b rises");
        tick(6);
        cmd_b = 1'b0;
        exp_at(1, 0, 1, 0, 0, "R3 cmd_b ignored"); tick(2);
        cmd_a = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R4 b falls");
        exp_at(3, 0, 0, 0, 0, "R4 gap back");
        exp_at(4, 1, 0, 0, 0, "R3 a follows");
        tick(6);

        // R4 zero dead count
        dead_cycles = 10'd0; tick(2);
        cmd_a = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R4 D0 fall");
        exp_at(2, 0, 1, 0, 0, "R4 D0 one-cycle gap");
        tick(4);
        dead_cycles = 10'd3; tick(2);

        // R5 exclusive mode
        mode_sel = 2'd2; cmd_a = 1'b0; cmd_b = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R10 to exclusive");
        tick(10);
        cmd_a = 1'b1;
        exp_at(1, 1, 0, 0, 0, "R5 a alone"); tick(2);
        cmd_b = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R5 both high off");
        exp_at(3, 0, 0, 0, 0, "R5 both high stays off");
        tick(4);
        cmd_a = 1'b0;
        exp_at(1, 0, 1, 0, 0, "R5 b alone"); tick(2);
        cmd_a = 1'b1; cmd_b = 1'b0;
        exp_at(1, 0, 0, 0, 0, "R4 exclusive swap");
        exp_at(3, 0, 0, 0, 0, "R4 exclusive gap");
        exp_at(4, 1, 0, 0, 0, "R4 exclusive rise");
        tick(6);

        // R11 hold mode
        mode_sel = 2'd3; cmd_b = 1'b1;
        exp_at(1, 0, 0, 0, 0, "R11 hold");
        exp_at(8, 0, 0, 0, 0, "R11 hold steady");
        tick(10);

        // back to pass-through
        mode_sel = 2'd0; cmd_a = 1'b0; cmd_b = 1'b0;
        tick(8);
        cmd_a = 1'b1; cmd_b = 1'b1;
        exp_at(1, 1, 1, 0, 0, "R2 after return"); tick(2);

        // R7 / R8 fault with blocking count 5
        fault_a = 1'b1;
        exp_at(1, 0, 1, 1, 0, "R7 fault a"); tick(3);
        fault_a = 1'b0; cmd_a = 1'b0;
        exp_at(5, 0, 1, 1, 0, "R8 still blocking");
        exp_at(6, 0, 1, 0, 0, "R8 block done");
        tick(8);
        cmd_a = 1'b1;
        exp_at(1, 1, 1, 0, 0, "R8 recovered"); tick(2);

        // R9 rearm with command held high
        fault_b = 1'b1;
        exp_at(1, 1, 0, 0, 1, "R7 fault b"); tick(3);
        fault_b = 1'b0;
        exp_at(8, 1, 0, 0, 1, "R9 waits for low cmd");
        tick(10);
        cmd_b = 1'b0;
        exp_at(1, 1, 0, 0, 0, "R9 rearmed"); tick(2);
        cmd_b = 1'b1;
        exp_at(1, 1, 1, 0, 0, "R9 fresh edge"); tick(2);

        // R8 zero blocking count
        block_cycles = 16'd0; cmd_a = 1'b0; tick(2);
        fault_a = 1'b1;
        exp_at(1, 0, 1, 1, 0, "R7 fault a zero block"); tick(2);
        fault_a = 1'b0;
        exp_at(1, 0, 1, 0, 0, "R8 zero block clears"); tick(3);

        tick(3);
        done = 1'b1;
        if (sb_q.size() != 0) begin
            fails += sb_q.size();
            $display("FAIL scoreboard: %0d pending expectations, expected 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule